// File: doc/BRIEF.md
# Multi-Phase Ring-Oscillator Edge-Counting Readout

This block is the digital back end of an oscillator-based converter. A ring oscillator, outside this block, delivers M phase outputs whose toggle rate follows the analog input. On every rising edge of the sample clock the block registers every phase and compares it with the sample taken one period earlier. A phase that changed level in between raises its flag. Rising and falling transitions both raise it, so each phase acts as a one-bit counter running at twice the oscillator rate.

The flags are published as a registered M-bit vector. With evenly staggered phases, the flags that are set form one circular run of ones, and the start of that run moves from sample to sample. The vector can therefore drive a bank of unit DAC elements directly, and the elements rotate without any extra logic. In the same cycle an adder tree reduces the flags to a binary count from 0 to M. A valid flag marks the outputs once both sampling stages hold real data.

The counting is correct only while each phase changes level at most once per sample period. The oscillator frequency must therefore stay strictly between zero and half the sample rate. The nominal free-running rate is a quarter of the sample rate.

Top module: `ring_phase_readout`

## Requirements
- R1: While `rst` is high at a rising clock edge, all sampling registers, `therm_o`, `count_o` and `valid_o` are cleared to 0.
- R2: After `rst` falls, `valid_o` stays 0 for the first two rising edges. It is 1 from the third edge on and stays 1 until the next reset.
- R3: Each phase is registered at every rising edge, and a second register keeps the previous sample. Flag bit i is 1 exactly when those two samples of phase i differ, so a rising edge and a falling edge count the same.
- R4: A change on `phase_i[i]` that is first registered at edge k appears as `therm_o[i]` = 1 after edge k+1. It stays there for exactly one sample if the phase makes no further change.
- R5: `count_o` equals the number of ones in `therm_o`, in the same cycle.
- R6: `count_o` is `$clog2(M+1)` bits wide and always lies in 0..M. When all M phases toggle between two samples it reports exactly M.
- R7: Phases that hold their level produce `therm_o` = 0 and `count_o` = 0.
- R8: Phase i is a square wave with half period H that lags phase 0 by i·H/M, and H is longer than one sample period. The sum of `count_o` over N valid samples is then within ±M of N·M·T/H, where T is the sample period, which is 2·M·fosc/fs per sample.
- R9: Under the staggered stimulus of R8, the set bits of `therm_o` form at most one circular run. Reading bit 0 as following bit M-1, at most one bit position i has `therm_o[i]` = 1 and `therm_o[i-1]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | M | Oscillator phase levels, bit i is phase i |
| valid_o | output | 1 | Outputs carry a real two-sample comparison |
| therm_o | output | M | Registered per-phase transition flags |
| count_o | output | $clog2(M+1) | Number of set flags |

## Verification
A stuck or mis-wired stage register shows in `therm_o` one sample after the phase change that should have set or cleared its flag. A missing or double count then appears in `count_o` in that same cycle. A fault in the adder tree breaks the match between `count_o` and the popcount of `therm_o` on the first sample whose pattern reaches the bad node. A fill-state fault raises `valid_o` one edge too early or too late after reset. Long square-wave runs at several oscillator rates catch errors that only show as a drift of the accumulated count.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

    // Width of a count that must represent 0..m inclusive
    function automatic int unsigned cnt_width(input int unsigned m);
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

    // Number of tree levels for n leaves (at least one level)
    function automatic int unsigned tree_levels(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Pipeline fill progress after reset release
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_FULL  = 2'd2
    } fill_e;

endpackage

// File: rtl/rpr_phase_lane.sv
module rpr_phase_lane #(
    parameter int unsigned M = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [M-1:0] phase_i,
    output logic [M-1:0] flag_o
);

    // R3: one capture register and one history register per phase
    for (genvar i = 0; i < M; i++) begin : g_lane
        logic cur_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q  <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                cur_q  <= phase_i[i];
                prev_q <= cur_q;
            end
        end

        assign flag_o[i] = cur_q ^ prev_q;
    end

endmodule

// File: rtl/rpr_popcount.sv
module rpr_popcount #(
    parameter int unsigned N = 64,
    parameter int unsigned W = 7
) (
    input  logic [N-1:0] bits_i,
    output logic [W-1:0] sum_o
);

    localparam int unsigned LV = rpr_pkg::tree_levels(N);
    localparam int unsigned P  = 1 << LV;

    // Heap-ordered binary tree: node k has children 2k+1 and 2k+2
    logic [W-1:0] node [0:2*P-2];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_used
            assign node[P-1+i] = W'(bits_i[i]);
        end else begin : g_pad
            assign node[P-1+i] = '0;
        end
    end

    for (genvar k = 0; k < P - 1; k++) begin : g_add
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    assign sum_o = node[0];

endmodule

// File: rtl/rpr_fill_track.sv
module rpr_fill_track (
    input  logic clk,
    input  logic rst,
    output logic ready_o
);

    rpr_pkg::fill_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= rpr_pkg::FILL_EMPTY;
        end else begin
            unique case (state_q)
                rpr_pkg::FILL_EMPTY: state_q <= rpr_pkg::FILL_ONE;
                rpr_pkg::FILL_ONE:   state_q <= rpr_pkg::FILL_FULL;
                default:             state_q <= rpr_pkg::FILL_FULL;
            endcase
        end
    end

    // Both stages hold real samples once two edges have passed
    assign ready_o = (state_q == rpr_pkg::FILL_FULL);

endmodule

// File: rtl/ring_phase_readout.sv
module ring_phase_readout #(
    parameter int unsigned M  = 64,
    parameter int unsigned CW = rpr_pkg::cnt_width(M)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [M-1:0]  phase_i,
    output logic          valid_o,
    output logic [M-1:0]  therm_o,
    output logic [CW-1:0] count_o
);

    logic [M-1:0]  flags;
    logic [CW-1:0] flag_sum;
    logic          ready;

    rpr_phase_lane #(.M(M)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_i),
        .flag_o  (flags)
    );

    rpr_popcount #(.N(M), .W(CW)) u_sum (
        .bits_i (flags),
        .sum_o  (flag_sum)
    );

    rpr_fill_track u_fill (
        .clk     (clk),
        .rst     (rst),
        .ready_o (ready)
    );

    // R1, R4, R5: output register aligns flags and their sum
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            therm_o <= '0;
            count_o <= '0;
        end else begin
            valid_o <= ready;
            therm_o <= flags;
            count_o <= flag_sum;
        end
    end

    // R5
    count_matches_flags_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (32'(count_o) == 32'($countones(therm_o))));

    // R6
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(count_o) <= M);

    // R2
    valid_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid_o);

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);

endmodule

// File: tb/ring_phase_readout_test.sv
`timescale 1ns/1ps
module ring_phase_readout_test;

    localparam int unsigned M  = 64;
    localparam int unsigned CW = $clog2(M + 1);
    localparam int S = 64;   // model ticks per sample period

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [M-1:0]  phase_i = '0;
    logic          valid_o;
    logic [M-1:0]  therm_o;
    logic [CW-1:0] count_o;

    int n_pass = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [M-1:0] exp_q [$];
    logic [M-1:0] prev_vec;
    bit  in_sq = 1'b0;
    longint sq_sum;
    int  sq_nval;

    always #2.5 clk = ~clk;

    ring_phase_readout #(.M(M)) uut (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_i),
        .valid_o (valid_o),
        .therm_o (therm_o),
        .count_o (count_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int pop_of(input logic [M-1:0] v);
        int c = 0;
        for (int j = 0; j < M; j++) c += int'(v[j]);
        return c;
    endfunction

    function automatic int runs_of(input logic [M-1:0] v);
        int r = 0;
        for (int j = 0; j < M; j++)
            if (v[j] && !v[(j + M - 1) % M]) r++;
        return r;
    endfunction

    // Staggered square wave: phase i lags by i*halfp/M ticks
    function automatic logic [M-1:0] sq_vec(input int n, input int halfp);
        logic [M-1:0] v;
        for (int i = 0; i < M; i++) begin
            int off = (i * halfp) / M;
            v[i] = (((n * S + 2 * halfp - off) / halfp) % 2) == 1;
        end
        return v;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && valid_o && !finished) begin
            logic [M-1:0] e;
            if (exp_q.size() != 0) e = exp_q.pop_front();
            else e = '0;   // R7: held inputs give no flags
            chk(therm_o == e, "R3/R4 therm_o", longint'(therm_o), longint'(e));
            chk(int'(count_o) == pop_of(e), "R5 count_o", longint'(count_o), longint'(pop_of(e)));
            chk(int'(count_o) <= M, "R6 count range", longint'(count_o), longint'(M));
            if (in_sq) begin
                sq_sum += longint'(count_o);
                sq_nval++;
                chk(runs_of(therm_o) <= 1, "R9 rotating run", longint'(runs_of(therm_o)), 1);
            end
        end
    end

    task automatic do_reset(input logic [M-1:0] first);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: cleared state
        chk(therm_o == '0, "R1 therm_o reset", longint'(therm_o), 0);
        chk(count_o == '0, "R1 count_o reset", longint'(count_o), 0);
        chk(valid_o == 1'b0, "R1 valid_o reset", longint'(valid_o), 0);
        rst = 1'b0;
        phase_i = first;
        prev_vec = first;
    endtask

    task automatic apply(input logic [M-1:0] v);
        @(negedge clk);
        phase_i = v;
        exp_q.push_back(prev_vec ^ v);
        prev_vec = v;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic run_square(input int halfp, input int nsamp);
        real expect_sum;
        real diff;
        do_reset(sq_vec(0, halfp));
        sq_sum = 0;
        sq_nval = 0;
        in_sq = 1'b1;
        for (int n = 1; n <= nsamp; n++) apply(sq_vec(n, halfp));
        repeat (2) @(negedge clk);
        in_sq = 1'b0;
        @(negedge clk);
        expect_sum = real'(sq_nval) * real'(M) * real'(S) / real'(halfp);
        diff = real'(sq_sum) - expect_sum;
        if (diff < 0.0) diff = -diff;
        // R8: accumulated count matches 2*M*fosc/fs per sample
        chk(diff <= real'(M), "R8 window sum", sq_sum, longint'(expect_sum));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
            $finish;
        end
    end

    initial begin
        // R2: valid timing after release
        do_reset('0);
        @(negedge clk);
        chk(valid_o == 1'b0, "R2 valid after edge 1", longint'(valid_o), 0);
        @(negedge clk);
        chk(valid_o == 1'b0, "R2 valid after edge 2", longint'(valid_o), 0);
        @(negedge clk);
        chk(valid_o == 1'b1, "R2 valid after edge 3", longint'(valid_o), 1);
        @(negedge clk);
        chk(valid_o == 1'b1, "R2 valid stays high", longint'(valid_o), 1);

        // Directed patterns: full scale, single phase, hold, partial groups
        do_reset('0);
        apply('1);                          // R6: all toggle -> M
        apply('0);                          // R6: all fall -> M
        apply(M'(1) << 5);                  // R4: single rising phase
        apply(M'(1) << 5);                  // R7: held
        apply('0);                          // R3: falling edge counts
        apply({{(M-8){1'b0}}, 8'hFF});
        apply({{(M-8){1'b0}}, 8'hF0});
        apply({8'hA5, {(M-8){1'b0}}});
        apply({8'hA5, {(M-8){1'b0}}});      // R7: held
        apply({(M/2){2'b10}});
        apply({(M/2){2'b01}});              // R6: every phase toggles
        drain();

        // R8 and R9: staggered square waves at several rates
        run_square(2 * S, 200);             // nominal fs/4
        run_square(80, 300);
        run_square(S + 1, 300);             // just below fs/2
        run_square(5 * S, 400);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end

endmodule